// File: doc/BRIEF.md
# Common Interrupt Distribution Unit

This block takes a set of shared external interrupt lines and forwards each one to a group of processor cores. Every shared line has its own settings: a core mask, a distribution mode, a trigger type and a mask bit. Software changes these settings through a single command port. Each command names an operation and an interrupt number, and may carry a data word. A read command returns the settings through a registered read port. The mode word can therefore be updated one field at a time with a read-modify-write.

In broadcast mode an active interrupt reaches every core set in its core mask. In rotating mode it reaches exactly one core of the mask. A pointer moves to the next enabled core each time the interrupt becomes active again, and it wraps around. Rising-edge inputs are held in a pending latch until an acknowledge command clears it. Level inputs are passed through live. No line reaches any core until the global enable is on.

Top module: `cirq_distributor`

## Requirements
- R1: After reset, every interrupt is masked, the global enable is off, all core masks and mode words read as zero, and `core_irq` is zero.
- R2: Opcode 1 (set core mask) stores `cmd_data[NUM_CORE-1:0]` as the core mask of interrupt `cmd_irq`. Opcode 7 returns that mask zero-extended on `rd_data`, with `rd_valid` high one cycle after the command.
- R3: Opcode 2 stores the mode word. Bits [1:0] are the distribution field, where 2'b01 selects rotating delivery and any other value selects broadcast. Bit 4 is the trigger, where 1 means rising edge and 0 means level-high. Opcode 5 reads the word back, and every other bit reads as zero.
- R4: In broadcast mode an active interrupt drives every `core_irq` bit that is set in its core mask.
- R5: In rotating mode an active interrupt drives exactly one core. Each new activation picks the next set mask bit above the core used last, wrapping from the top core to core 0. The pointer starts at the top core, so the first delivery goes to the lowest set bit.
- R6: In edge mode a rising edge sets a pending latch. The interrupt stays active after the input falls, until it is acknowledged.
- R7: In level mode the interrupt is active exactly while the input is high. Nothing is latched.
- R8: Opcode 3 with `cmd_data[0]`=1 masks the interrupt and with 0 unmasks it. A masked interrupt drives no core, but an edge that arrives while masked stays pending.
- R9: Opcode 6 sets the global enable from `cmd_data[0]`. While it is off no core is driven, though edges still latch.
- R10: Opcode 4 clears the pending latch of `cmd_irq`. A rising edge in the same cycle as the acknowledge wins, and the interrupt stays pending.
- R11: `core_irq` is registered: it reflects inputs and settings as sampled on the previous clock edge.
- R12: When several interrupts are active, their core sets are ORed onto `core_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode (0 none, 1 set mask of cores, 2 set mode, 3 set mask bit, 4 acknowledge, 5 read mode, 6 global enable, 7 read core mask) |
| cmd_irq | input | IW | Interrupt number the command refers to |
| cmd_data | input | 32 | Command data word |
| rd_valid | output | 1 | Read data valid, one cycle after a read command |
| rd_data | output | 32 | Read data |
| irq_in | input | NUM_IRQ | Shared interrupt inputs |
| core_irq | output | NUM_CORE | Interrupt request to each core |

## Verification
An acknowledge and a fresh rising edge on the same line can arrive in the same cycle. The bench provokes this by raising the input in the very cycle it issues the acknowledge for a pending edge interrupt. The result must be that the core request stays asserted rather than dropping. The bench also unmasks and re-enables interrupts whose edges were latched while blocked, and overlaps a level source with an edge source. A behavioural reference model judges every cycle against `core_irq` and the read port.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_SET_CORES = 3'd1,
    OP_SET_MODE  = 3'd2,
    OP_SET_MASK  = 3'd3,
    OP_ACK       = 3'd4,
    OP_RD_MODE   = 3'd5,
    OP_ENABLE    = 3'd6,
    OP_RD_CORES  = 3'd7
  } cirq_op_e;

  localparam logic [1:0] DISTR_ROTATE = 2'b01;

  typedef struct packed {
    logic       edge_trig;
    logic [1:0] distr;
  } cirq_mode_t;

  function automatic logic [DATA_W-1:0] mode_to_word(cirq_mode_t m);
    logic [DATA_W-1:0] w;
    w = '0;
    w[1:0] = m.distr;
    w[4]   = m.edge_trig;
    return w;
  endfunction
endpackage

// File: rtl/cirq_cfg.sv
module cirq_cfg
  import cirq_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_CORE = 4,
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cmd_valid,
  input  logic [2:0]                       cmd_op,
  input  logic [IW-1:0]                    cmd_irq,
  input  logic [DATA_W-1:0]                cmd_data,
  output logic [NUM_IRQ-1:0][NUM_CORE-1:0] cores_q,
  output cirq_mode_t [NUM_IRQ-1:0]         mode_q,
  output logic [NUM_IRQ-1:0]               mask_q,
  output logic                             en_q,
  output logic [NUM_IRQ-1:0]               ack_vec,
  output logic                             rd_valid,
  output logic [DATA_W-1:0]                rd_data
);
  logic     in_range;
  cirq_op_e op;
  logic     unused_data;

  assign in_range    = int'(cmd_irq) < NUM_IRQ;
  assign op          = cirq_op_e'(cmd_op);
  assign unused_data = ^cmd_data;

  always_comb begin
    ack_vec = '0;
    if (cmd_valid && in_range && op == OP_ACK) ack_vec[cmd_irq] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cores_q  <= '0;
      mode_q   <= '0;
      mask_q   <= '1;
      en_q     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (cmd_valid) begin
        case (op)
          OP_ENABLE: en_q <= cmd_data[0];
          OP_SET_CORES: if (in_range) cores_q[cmd_irq] <= cmd_data[NUM_CORE-1:0];
          OP_SET_MODE: if (in_range) begin
            mode_q[cmd_irq].edge_trig <= cmd_data[4];
            mode_q[cmd_irq].distr     <= cmd_data[1:0];
          end
          OP_SET_MASK: if (in_range) mask_q[cmd_irq] <= cmd_data[0];
          OP_RD_MODE: if (in_range) begin
            rd_valid <= 1'b1;
            rd_data  <= mode_to_word(mode_q[cmd_irq]);
          end
          OP_RD_CORES: if (in_range) begin
            rd_valid <= 1'b1;
            rd_data  <= DATA_W'(cores_q[cmd_irq]);
          end
          default: ;
        endcase
      end
    end
  end

  // R1: the cycle after reset every line is still masked
  assert_reset_masked_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_q && !en_q));

  // R3: read data is only presented after a read command
  assert_rd_after_read_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cmd_valid && (cmd_op == OP_RD_MODE || cmd_op == OP_RD_CORES)));
endmodule

// File: rtl/cirq_source.sv
module cirq_source
  import cirq_pkg::*;
#(
  parameter int NUM_CORE = 4,
  localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                irq_i,
  input  logic                en_i,
  input  logic                mask_i,
  input  logic                ack_i,
  input  logic [NUM_CORE-1:0] cores_i,
  input  cirq_mode_t          mode_i,
  output logic [NUM_CORE-1:0] hit_o
);
  logic          prev_q, pend_q, act_q;
  logic [CW-1:0] ptr_q, nxt, sel;
  logic          rise, src, act, rotate, fresh;

  assign rise   = irq_i & ~prev_q;
  assign src    = mode_i.edge_trig ? (pend_q | rise) : irq_i;
  assign act    = src & en_i & ~mask_i;
  assign rotate = (mode_i.distr == DISTR_ROTATE);
  assign fresh  = act & ~act_q;

  // next set bit above the last used core, wrapping
  always_comb begin
    logic found;
    int   idx;
    nxt   = ptr_q;
    found = 1'b0;
    for (int k = 1; k <= NUM_CORE; k++) begin
      idx = (int'(ptr_q) + k) % NUM_CORE;
      if (!found && cores_i[idx]) begin
        nxt   = CW'(idx);
        found = 1'b1;
      end
    end
  end

  assign sel = fresh ? nxt : ptr_q;

  always_comb begin
    for (int c = 0; c < NUM_CORE; c++) begin
      if (rotate) hit_o[c] = act & cores_i[c] & (sel == CW'(c));
      else        hit_o[c] = act & cores_i[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      ptr_q  <= CW'(NUM_CORE - 1);
    end else begin
      prev_q <= irq_i;
      act_q  <= act;
      pend_q <= (pend_q & ~ack_i) | (mode_i.edge_trig & rise);
      if (rotate && fresh) ptr_q <= nxt;
    end
  end

  // R5: rotating delivery never targets more than one core
  assert_rotate_single_R5: assert property (@(posedge clk) disable iff (rst)
    rotate |-> $onehot0(hit_o));

  // R6: a latched edge survives until acknowledged
  assert_pending_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack_i) |=> pend_q);

  // R8: a masked line reaches no core
  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    mask_i |-> (hit_o == '0));
endmodule

// File: rtl/cirq_distributor.sv
module cirq_distributor
  import cirq_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_CORE = 4,
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [IW-1:0]       cmd_irq,
  input  logic [31:0]         cmd_data,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  input  logic [NUM_IRQ-1:0]  irq_in,
  output logic [NUM_CORE-1:0] core_irq
);
  logic [NUM_IRQ-1:0][NUM_CORE-1:0] cores_q;
  cirq_mode_t [NUM_IRQ-1:0]         mode_q;
  logic [NUM_IRQ-1:0]               mask_q;
  logic                             en_q;
  logic [NUM_IRQ-1:0]               ack_vec;
  logic [NUM_IRQ-1:0][NUM_CORE-1:0] hits;
  logic [NUM_CORE-1:0]              merged;

  cirq_cfg #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE)) u_cfg (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_irq(cmd_irq), .cmd_data(cmd_data),
    .cores_q(cores_q), .mode_q(mode_q), .mask_q(mask_q), .en_q(en_q),
    .ack_vec(ack_vec), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    cirq_source #(.NUM_CORE(NUM_CORE)) u_src (
      .clk(clk), .rst(rst),
      .irq_i(irq_in[i]), .en_i(en_q), .mask_i(mask_q[i]), .ack_i(ack_vec[i]),
      .cores_i(cores_q[i]), .mode_i(mode_q[i]), .hit_o(hits[i])
    );
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_IRQ; i++) merged |= hits[i];
  end

  always_ff @(posedge clk) begin
    if (rst) core_irq <= '0;
    else     core_irq <= merged;
  end

  // R9: with the global enable off, the next cycle drives no core
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (core_irq == '0));
endmodule

// File: tb/sim_cirq_distributor.sv
`timescale 1ns/1ps
module sim_cirq_distributor;
  localparam int NI = 4;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_irq = '0;
  logic [31:0] cmd_data = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [NI-1:0] irq_in = '0;
  logic [NC-1:0] core_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  cirq_distributor #(.NUM_IRQ(NI), .NUM_CORE(NC)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_irq(cmd_irq),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_in(irq_in), .core_irq(core_irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [NC-1:0] m_cores [NI];
  int            m_distr [NI];
  bit            m_edge  [NI];
  bit            m_mask  [NI];
  bit            m_pend  [NI];
  bit            m_prev  [NI];
  bit            m_act   [NI];
  int            m_ptr   [NI];
  bit            m_en;
  logic [NC-1:0] exp_core = '0;
  bit            exp_rdv = 0;
  logic [31:0]   exp_rd = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NI; i++) begin
        m_cores[i] = '0; m_distr[i] = 0; m_edge[i] = 0; m_mask[i] = 1;
        m_pend[i] = 0; m_prev[i] = 0; m_act[i] = 0; m_ptr[i] = NC - 1;
      end
      m_en = 0; exp_core = '0; exp_rdv = 0; exp_rd = '0;
    end else begin
      logic [NC-1:0] nc;
      nc = '0;
      for (int i = 0; i < NI; i++) begin
        bit rise, src, act, ackd, found;
        rise = irq_in[i] && !m_prev[i];
        src  = m_edge[i] ? (m_pend[i] || rise) : irq_in[i];
        act  = src && m_en && !m_mask[i];
        if (act) begin
          if (m_distr[i] == 1) begin
            if (!m_act[i]) begin
              found = 0;
              for (int k = 1; k <= NC; k++) begin
                int j;
                j = (m_ptr[i] + k) % NC;
                if (!found && m_cores[i][j]) begin m_ptr[i] = j; found = 1; end
              end
            end
            if (m_cores[i][m_ptr[i]]) nc[m_ptr[i]] = 1'b1;
          end else begin
            nc |= m_cores[i];
          end
        end
        ackd = cmd_valid && cmd_op == 3'd4 && cmd_irq == i;
        m_pend[i] = (m_pend[i] && !ackd) || (m_edge[i] && rise);
        m_prev[i] = irq_in[i];
        m_act[i]  = act;
      end
      exp_rdv = 0;
      if (cmd_valid) begin
        case (cmd_op)
          3'd1: m_cores[cmd_irq] = cmd_data[NC-1:0];
          3'd2: begin m_distr[cmd_irq] = (cmd_data[1:0] == 2'b01) ? 1 : 0;
                      m_edge[cmd_irq] = cmd_data[4];
                      exp_rd = {27'b0, cmd_data[4], 2'b0, cmd_data[1:0]}; end
          3'd3: m_mask[cmd_irq] = cmd_data[0];
          3'd5: begin exp_rdv = 1;
                      exp_rd = {27'b0, m_edge[cmd_irq], 2'b0, 2'(m_distr[cmd_irq])}; end
          3'd6: m_en = cmd_data[0];
          3'd7: begin exp_rdv = 1; exp_rd = 32'(m_cores[cmd_irq]); end
          default: ;
        endcase
      end
      exp_core = nc;
    end
  end

  // Per-cycle comparison against the model (R11 timing, all functions)
  logic [1:0] m_distr_raw [NI];
  always @(posedge clk) if (!rst && cmd_valid && cmd_op == 3'd2) m_distr_raw[cmd_irq] <= cmd_data[1:0];

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(32'(core_irq), 32'(exp_core), "R11 cycle model core_irq");
      check(32'(rd_valid), 32'(exp_rdv), "R11 cycle model rd_valid");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_cmd(input logic [2:0] op, input int irq, input logic [31:0] data);
    cmd_valid = 1'b1; cmd_op = op; cmd_irq = 2'(irq); cmd_data = data;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
  endtask

  task automatic tick2();
    repeat (2) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic pulse(input int i);
    irq_in[i] = 1'b1;
    @(posedge clk); @(negedge clk);
    irq_in[i] = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);

    // R1 reset state
    check(32'(core_irq), 0, "R1 core_irq after reset");
    do_cmd(3'd5, 0, 0);  check(rd_data, 0, "R1 mode word after reset");
    do_cmd(3'd7, 3, 0);  check(rd_data, 0, "R1 core mask after reset");
    do_cmd(3'd1, 1, 32'h6); do_cmd(3'd6, 0, 1); irq_in[1] = 1'b1; tick2();
    check(32'(core_irq), 0, "R1 lines masked after reset");
    irq_in[1] = 1'b0; do_cmd(3'd6, 0, 0); tick2();

    // R2 core mask write and read
    do_cmd(3'd1, 0, 32'h5); do_cmd(3'd7, 0, 0); check(rd_data, 32'h5, "R2 core mask readback");
    do_cmd(3'd1, 3, 32'hFFFF_FFFB); do_cmd(3'd7, 3, 0); check(rd_data, 32'hB, "R2 core mask width");

    // R3 mode word layout
    do_cmd(3'd2, 1, 32'hFFFF_FFFF); do_cmd(3'd5, 1, 0); check(rd_data, 32'h13, "R3 mode word reserved bits");
    do_cmd(3'd2, 1, 32'h0); do_cmd(3'd5, 1, 0); check(rd_data, 32'h0, "R3 mode word cleared");

    // R9 global enable, R4 broadcast, R8 mask, R7 level
    do_cmd(3'd3, 0, 0); irq_in[0] = 1'b1; tick2();
    check(32'(core_irq), 0, "R9 no delivery before enable");
    do_cmd(3'd6, 0, 1); tick2();
    check(32'(core_irq), 32'h5, "R4 broadcast to core mask");
    do_cmd(3'd3, 0, 1); tick2();
    check(32'(core_irq), 0, "R8 masked level line");
    do_cmd(3'd3, 0, 0); tick2();
    check(32'(core_irq), 32'h5, "R8 unmasked level line");
    irq_in[0] = 1'b0; tick2();
    check(32'(core_irq), 0, "R7 level follows input low");

    // R6 edge latch, R10 acknowledge
    do_cmd(3'd1, 2, 32'h8); do_cmd(3'd2, 2, 32'h10); do_cmd(3'd3, 2, 0);
    pulse(2); tick2();
    check(32'(core_irq), 32'h8, "R6 edge held after input falls");
    do_cmd(3'd4, 2, 0); tick2();
    check(32'(core_irq), 0, "R10 acknowledge clears pending");

    // R10 acknowledge and new edge in the same cycle
    pulse(2); tick2();
    irq_in[2] = 1'b1; do_cmd(3'd4, 2, 0); tick2();
    check(32'(core_irq), 32'h8, "R10 edge wins over same-cycle ack");
    irq_in[2] = 1'b0; do_cmd(3'd4, 2, 0); tick2();
    check(32'(core_irq), 0, "R10 later ack clears");

    // R8 edge latched while masked
    do_cmd(3'd3, 2, 1); pulse(2); tick2();
    check(32'(core_irq), 0, "R8 masked edge not delivered");
    do_cmd(3'd3, 2, 0); tick2();
    check(32'(core_irq), 32'h8, "R8 edge kept pending while masked");
    do_cmd(3'd4, 2, 0); tick2();

    // R9 edge latched while disabled
    do_cmd(3'd6, 0, 0); pulse(2); tick2();
    check(32'(core_irq), 0, "R9 disabled blocks edge");
    do_cmd(3'd6, 0, 1); tick2();
    check(32'(core_irq), 32'h8, "R9 pending delivered after enable");
    do_cmd(3'd4, 2, 0); tick2();

    // R5 rotating delivery over core mask 4'b1011
    do_cmd(3'd2, 3, 32'h11); do_cmd(3'd3, 3, 0);
    begin
      logic [3:0] seq [4] = '{4'h1, 4'h2, 4'h8, 4'h1};
      for (int n = 0; n < 4; n++) begin
        pulse(3); tick2();
        check(32'(core_irq), 32'(seq[n]), "R5 rotating target");
        do_cmd(3'd4, 3, 0); tick2();
        check(32'(core_irq), 0, "R5 rotating released");
      end
    end

    // R12 concurrent lines OR together
    irq_in[0] = 1'b1; pulse(2); tick2();
    check(32'(core_irq), 32'hD, "R12 overlapping lines merged");
    irq_in[0] = 1'b0; do_cmd(3'd4, 2, 0); tick2();
    check(32'(core_irq), 0, "R12 all released");

    finish_run();
  end
endmodule